// File: doc/BRIEF.md
# Trigger-Selectable Interrupt Request Latch

This block turns a set of raw interrupt request lines into a vector of pending bits. Every line is individually configured, at run time, to behave as edge-sensitive or level-sensitive through a trigger-mode register. An edge-sensitive line latches a request when it sees a rising level and holds it until the line is acknowledged. A level-sensitive line simply mirrors its synchronised input.

Request inputs are treated as asynchronous and pass through a synchroniser before edge detection. A downstream arbiter reads the pending vector, picks a line, and reports its index back on the acknowledge port. Arbitration, masking and in-service state all belong to that arbiter and not to this block. A build parameter fixes which trigger-mode bits can be written, so a given instance can tie some lines permanently to edge behaviour. An initialisation strobe clears the request state without touching the trigger configuration.

Top module: `trl_top`

## Requirements
- R1: While `rst_n` is low, `pending` and `mode_out` read all zeros.
- R2: For a line whose `mode_out` bit is 1 (level), `pending` equals the input level seen through the synchroniser. A change on `req_in` sampled at one clock edge shows on `pending` after the third rising edge.
- R3: For a line whose `mode_out` bit is 0 (edge), a low-to-high change sets the pending bit, and a later return to low leaves it set.
- R4: An edge line that stays high after its bit has been acknowledged does not set again until its input has gone low and then high again.
- R5: An `ack_valid` pulse with index `ack_idx` clears the pending bit of that edge line on the same clock edge and leaves every other line unchanged.
- R6: An acknowledge aimed at a level line does not change its pending bit.
- R7: A write through `mode_wr_en` loads `mode_wr_data` AND `WR_MASK` into the trigger-mode register on that clock edge. Bits that are zero in `WR_MASK` always read 0, so the default mask 0xF8 keeps lines 0 to 2 edge-sensitive.
- R8: A pulse on `init` clears every pending bit and every stored previous level on that clock edge and keeps `mode_out`. An edge line that is still high afterwards is detected again on the next edge.
- R9: If an acknowledge and a new rising edge reach the same edge line on the same clock edge, the pending bit ends up set.
- R10: The stored previous level of each line is updated on every clock edge in both modes. A line held high in level mode and then switched to edge mode therefore produces no new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous clear of request state |
| req_in | input | NUM_LINES | Raw request lines, asynchronous |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | $clog2(NUM_LINES) | Index of the acknowledged line |
| mode_wr_en | input | 1 | Trigger-mode write enable |
| mode_wr_data | input | NUM_LINES | Trigger-mode write data, 1 = level |
| pending | output | NUM_LINES | Pending request vector |
| mode_out | output | NUM_LINES | Current trigger-mode register |

## Verification
The bench targets the cases where an edge line and its acknowledge interact. A design that let the acknowledge win over a new edge in the same cycle would lose that request. A design that re-armed the edge detector while the input stayed high would report the same request twice. It also switches a line from level to edge mode while the input is held high. A design that refreshed the previous level only in edge mode would then invent a spurious edge. Further checks confirm that an acknowledge on a level line is ignored, that the hard-wired mode bits cannot be written, and that a line still high after `init` is caught again.

// File: rtl/trl_pkg.sv
package trl_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Rising transition between the previous and current synchronised sample.
  function automatic logic rise_seen(input logic now_lvl, input logic old_lvl);
    return now_lvl & ~old_lvl;
  endfunction

  // Next value of one pending bit.
  function automatic logic next_pend(
    input trig_mode_e mode,
    input logic       now_lvl,
    input logic       old_lvl,
    input logic       cur,
    input logic       ack
  );
    logic res;
    if (mode == TRIG_LEVEL) begin
      res = now_lvl;
    end else if (rise_seen(now_lvl, old_lvl)) begin
      res = 1'b1;
    end else if (ack) begin
      res = 1'b0;
    end else begin
      res = cur;
    end
    return res;
  endfunction

  // Value stored on a trigger-mode write.
  function automatic logic [63:0] apply_mask(input logic [63:0] data, input logic [63:0] mask);
    return data & mask;
  endfunction

endpackage

// File: rtl/trl_sync.sv
module trl_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/trl_mode_reg.sv
module trl_mode_reg #(
  parameter int unsigned    WIDTH   = 8,
  parameter logic [WIDTH-1:0] WR_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mode_q
);

  import trl_pkg::*;

  logic [63:0] masked_wide;
  logic [WIDTH-1:0] masked;

  assign masked_wide = apply_mask(64'(wr_data), 64'(WR_MASK));
  assign masked      = masked_wide[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= masked;
  end

endmodule

// File: rtl/trl_ack_dec.sv
module trl_ack_dec #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  output logic [WIDTH-1:0] hit
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_hit
      assign hit[i] = valid && (idx == IDX_W'(i));
    end
  endgenerate

endmodule

// File: rtl/trl_line.sv
module trl_line (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic lvl_mode,
  input  logic sync_in,
  input  logic ack_hit,
  output logic pend_q,
  output logic prev_q,
  output logic edge_evt
);

  import trl_pkg::*;

  logic pend_d;

  assign edge_evt = rise_seen(sync_in, prev_q);
  assign pend_d   = next_pend(trig_mode_e'(lvl_mode), sync_in, prev_q, pend_q, ack_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (init) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      prev_q <= sync_in;
    end
  end

endmodule

// File: rtl/trl_top.sv
module trl_top #(
  parameter int unsigned          NUM_LINES   = 8,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] WR_MASK     = 8'hF8,
  localparam int unsigned         IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  input  logic                 mode_wr_en,
  input  logic [NUM_LINES-1:0] mode_wr_data,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] mode_out
);

  // Named internal events, observed by the bound checker.
  logic [NUM_LINES-1:0] sync_lvl;
  logic [NUM_LINES-1:0] prev_lvl;
  logic [NUM_LINES-1:0] edge_evt;
  logic [NUM_LINES-1:0] ack_hit;
  logic [NUM_LINES-1:0] mode_q;

  trl_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (req_in),
    .d_out (sync_lvl)
  );

  trl_mode_reg #(.WIDTH(NUM_LINES), .WR_MASK(WR_MASK)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode_q  (mode_q)
  );

  trl_ack_dec #(.WIDTH(NUM_LINES), .IDX_W(IDX_W)) u_ack (
    .valid (ack_valid),
    .idx   (ack_idx),
    .hit   (ack_hit)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_line
      trl_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .lvl_mode (mode_q[i]),
        .sync_in  (sync_lvl[i]),
        .ack_hit  (ack_hit[i]),
        .pend_q   (pending[i]),
        .prev_q   (prev_lvl[i]),
        .edge_evt (edge_evt[i])
      );
    end
  endgenerate

  assign mode_out = mode_q;

endmodule

// File: rtl/trl_checker.sv
module trl_checker #(
  parameter int unsigned          NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = 8'hF8,
  parameter int unsigned          IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 init,
  input logic                 ack_valid,
  input logic [IDX_W-1:0]     ack_idx,
  input logic                 mode_wr_en,
  input logic [NUM_LINES-1:0] mode_wr_data,
  input logic [NUM_LINES-1:0] pending,
  input logic [NUM_LINES-1:0] mode_out,
  input logic [NUM_LINES-1:0] sync_lvl,
  input logic [NUM_LINES-1:0] prev_lvl,
  input logic [NUM_LINES-1:0] edge_evt
);

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> mode_out == ($past(mode_wr_data) & WR_MASK)); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_en |=> $stable(mode_out)); // R8

  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (pending == '0) && (prev_lvl == '0)); // R8

  AST_PREV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> prev_lvl == $past(sync_lvl)); // R10

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_chk
      AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out[i] && !init) |=> pending[i] == $past(sync_lvl[i])); // R2

      AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out[i] && edge_evt[i] && !init) |=> pending[i]); // R3

      AST_EDGE_WINS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out[i] && edge_evt[i] && ack_valid && ack_idx == IDX_W'(i) && !init) |=> pending[i]); // R9

      AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out[i] && !edge_evt[i] && ack_valid && ack_idx == IDX_W'(i) && !init) |=> !pending[i]); // R5

      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out[i] && pending[i] && !(ack_valid && ack_idx == IDX_W'(i)) && !init) |=> pending[i]); // R3

      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out[i] && !pending[i] && !edge_evt[i]) |=> !pending[i]); // R4
    end
  endgenerate

endmodule

bind trl_top trl_checker #(.NUM_LINES(NUM_LINES), .WR_MASK(WR_MASK), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init         (init),
  .ack_valid    (ack_valid),
  .ack_idx      (ack_idx),
  .mode_wr_en   (mode_wr_en),
  .mode_wr_data (mode_wr_data),
  .pending      (pending),
  .mode_out     (mode_out),
  .sync_lvl     (sync_lvl),
  .prev_lvl     (prev_lvl),
  .edge_evt     (edge_evt)
);

// File: tb/sim_trl_top.sv
module sim_trl_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0;
  logic [7:0] req_in = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_idx = '0;
  logic       mode_wr_en = 1'b0;
  logic [7:0] mode_wr_data = '0;
  logic [7:0] pending;
  logic [7:0] mode_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] pend;
    logic [7:0] mode;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur_e;

  always #5 clk = ~clk;

  trl_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .init         (init),
    .req_in       (req_in),
    .ack_valid    (ack_valid),
    .ack_idx      (ack_idx),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .pending      (pending),
    .mode_out     (mode_out)
  );

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      cur_e = sb_q.pop_front();
      checks++;
      if (pending !== cur_e.pend || mode_out !== cur_e.mode) begin
        fails++;
        $display("FAIL %s: pending=%02h mode=%02h, expected pending=%02h mode=%02h",
                 cur_e.tag, pending, mode_out, cur_e.pend, cur_e.mode);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input string tag, input logic [7:0] p, input logic [7:0] m);
    exp_t e;
    e.tag = tag; e.pend = p; e.mode = m;
    sb_q.push_back(e);
  endtask

  task automatic wr_mode(input logic [7:0] d);
    @(negedge clk); mode_wr_en = 1'b1; mode_wr_data = d;
    @(negedge clk); mode_wr_en = 1'b0;
  endtask

  task automatic do_ack(input logic [2:0] idx);
    @(negedge clk); ack_valid = 1'b1; ack_idx = idx;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic set_req(input int line, input logic v);
    @(negedge clk); req_in[line] = v;
  endtask

  task automatic print_summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run state=hung, expected=complete");
      print_summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(3);
    expect_st("R1 reset", 8'h00, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    expect_st("R1 after release", 8'h00, 8'h00);

    // R7: mask on trigger-mode writes
    wr_mode(8'hFF); tick(1);
    expect_st("R7 all ones masked", 8'h00, 8'hF8);
    wr_mode(8'h07); tick(1);
    expect_st("R7 hard-wired bits", 8'h00, 8'h00);
    wr_mode(8'h28); tick(1);
    expect_st("R7 lines 3 and 5 level", 8'h00, 8'h28);

    // R2: level line follows input with three-edge latency
    set_req(3, 1'b1); tick(2);
    expect_st("R2 latency not yet", 8'h00, 8'h28);
    tick(1);
    expect_st("R2 level high", 8'h08, 8'h28);
    set_req(3, 1'b0); tick(3);
    expect_st("R2 level low", 8'h00, 8'h28);

    // R3: edge lines latch and hold
    @(negedge clk); req_in[0] = 1'b1; req_in[1] = 1'b1; tick(3);
    expect_st("R3 edge set", 8'h03, 8'h28);
    @(negedge clk); req_in[0] = 1'b0; req_in[1] = 1'b0; tick(3);
    expect_st("R3 edge hold after fall", 8'h03, 8'h28);

    // R5: acknowledge clears only the selected line
    do_ack(3'd1); tick(1);
    expect_st("R5 ack line 1", 8'h01, 8'h28);
    do_ack(3'd0); tick(1);
    expect_st("R5 ack line 0", 8'h00, 8'h28);

    // R4: held-high edge line does not re-set
    set_req(2, 1'b1); tick(3);
    expect_st("R4 edge set", 8'h04, 8'h28);
    do_ack(3'd2); tick(4);
    expect_st("R4 no re-set while high", 8'h00, 8'h28);
    set_req(2, 1'b0); tick(3);
    expect_st("R4 still clear after fall", 8'h00, 8'h28);
    set_req(2, 1'b1); tick(3);
    expect_st("R4 new edge sets", 8'h04, 8'h28);
    do_ack(3'd2); set_req(2, 1'b0); tick(3);
    expect_st("R4 cleanup", 8'h00, 8'h28);

    // R6: acknowledge on level line has no effect
    set_req(5, 1'b1); tick(3);
    expect_st("R6 level pending", 8'h20, 8'h28);
    do_ack(3'd5); tick(1);
    expect_st("R6 ack ignored", 8'h20, 8'h28);
    set_req(5, 1'b0); tick(3);
    expect_st("R6 level cleared by input", 8'h00, 8'h28);

    // R9: acknowledge and new edge in the same cycle
    set_req(1, 1'b1); tick(3);
    set_req(1, 1'b0); tick(3);
    expect_st("R9 setup pending", 8'h02, 8'h28);
    @(negedge clk); req_in[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); ack_valid = 1'b1; ack_idx = 3'd1;
    tick(1);
    expect_st("R9 edge beats ack", 8'h02, 8'h28);
    @(negedge clk); ack_valid = 1'b0;
    do_ack(3'd1); tick(1);
    expect_st("R9 later ack clears", 8'h00, 8'h28);
    set_req(1, 1'b0); tick(3);

    // R10: previous level tracked in level mode
    set_req(3, 1'b1); tick(3);
    expect_st("R10 level high", 8'h08, 8'h28);
    wr_mode(8'h20); tick(1);
    expect_st("R10 switch to edge keeps bit", 8'h08, 8'h20);
    do_ack(3'd3); tick(3);
    expect_st("R10 no false edge", 8'h00, 8'h20);
    set_req(3, 1'b0); tick(3);

    // R8: init clears state, keeps mode, re-detects high edge line
    set_req(4, 1'b1); tick(3);
    set_req(5, 1'b1); tick(3);
    expect_st("R8 setup", 8'h30, 8'h20);
    @(negedge clk); init = 1'b1;
    tick(1);
    expect_st("R8 init clears", 8'h00, 8'h20);
    @(negedge clk); init = 1'b0;
    tick(1);
    expect_st("R8 re-detect after init", 8'h30, 8'h20);

    tick(2);
    done = 1'b1;
    print_summary();
    $finish;
  end

endmodule